// File: doc/BRIEF.md
# Dual-Rate Token Bucket Shaper

This block limits the transmit rate of one scheduling node with two token buckets: a peak bucket and a committed bucket. Each bucket has its own refill code, burst-cap code and divider counter. A refill is added once per coarse time-wheel period, not on every clock. Both the refill amount and the burst cap use a floating-point style code: an 8-bit mantissa with an implicit leading 256 and a 4-bit exponent. A third field, the divider exponent, stretches the refill period by a power of two.

A packet is offered as a byte length with a valid/ready handshake. The peak bucket decides whether the packet may leave. The committed bucket decides its conformance colour. Each bucket holds a signed count in units of 1/256 token, so a slow code can add fractions of a token per period. Clearing a bucket's enable bit makes that bucket always conform, which gives single-rate operation. Each bucket's settings are written as one word, selected by `cfg_sel`.

Top module: `dual_rate_shaper`

## Requirements
- R1: On each refill, a bucket adds (256 + rate mantissa) << rate exponent, in 1/256-token units. The rate mantissa is 8 bits and the rate exponent is 4 bits (0 to 15).
- R2: A bucket's refills fall every TICKS << d clock cycles, counted from the last configuration write or reset. The first refill comes TICKS << d edges after that write. Here d is the divider exponent, and any value above 12 acts as 12.
- R3: The burst cap in whole tokens is ((256 + burst mantissa) << (burst exponent + 1)) / 256, rounded down. After a refill, a bucket never holds more than its cap.
- R4: When the peak bucket is non-negative or disabled, and no configuration write is in progress, `pkt_ready` is 1. When a packet is accepted, its length in tokens is subtracted from every enabled bucket, and either bucket may go below zero.
- R5: `pkt_colour` is 0 (green) when both buckets conform, 1 (yellow) when only the peak bucket conforms, and 2 (red) when the peak bucket is negative. Red always comes with `pkt_ready` low.
- R6: After reset, both buckets are enabled with mantissas 0, exponents 0 and divider exponent 12, and both are full to their 2-token cap. A stream of 1-token packets then gets three green acceptances before it is held.
- R7: A write with `cfg_we` high stores the fields in the peak bucket (`cfg_sel` = 0) or the committed bucket (`cfg_sel` = 1). The write reloads both buckets to their caps under the new settings and clears both divider counters. `pkt_ready` is 0 during the write cycle.
- R8: A bucket whose enable field is 0 always conforms. A disabled peak bucket never holds a packet. A disabled committed bucket makes every accepted packet green.
- R9: Fractional refills accumulate exactly: a refill of 1.5 or 1.996 tokens per period brings a bucket back to zero after the number of periods that exact arithmetic predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Bucket to write: 0 peak, 1 committed |
| cfg_en | input | 1 | Bucket enable field |
| cfg_rate_man | input | 8 | Refill mantissa |
| cfg_rate_exp | input | 4 | Refill exponent |
| cfg_div_exp | input | 4 | Refill period divider exponent |
| cfg_burst_man | input | 8 | Burst cap mantissa |
| cfg_burst_exp | input | 4 | Burst cap exponent |
| pkt_valid | input | 1 | Packet offered |
| pkt_len | input | LEN_W | Packet length in tokens (bytes) |
| pkt_ready | output | 1 | Packet may leave this cycle |
| pkt_colour | output | 2 | Conformance colour of the offered packet |

## Verification
On every cycle, the assertions check four things. A bucket never ends a refill cycle above its cap. A deduction from a non-negative bucket removes exactly the packet length. A reload lands on the new cap. The divider counter stays inside its period. They also check that red and configuration writes always hold the packet. Only the bench scenarios can show the refill arithmetic itself. They do so by measuring the cycle on which a drained bucket becomes eligible again, which also covers the clamped divider exponent. The bench also counts how many packets a full bucket passes, and which of them are green and which are yellow.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

  localparam int MAN_W   = 8;
  localparam int EXP_W   = 4;
  localparam int FRAC_W  = 8;
  localparam int DIV_MAX = 12;
  // (256+255) << 16 needs 25 bits; (256+255) << 15 needs 24 bits
  localparam int CAP_W   = MAN_W + 1 + 16;
  localparam int REF_W   = MAN_W + 1 + 15;

  typedef struct packed {
    logic             en;
    logic [MAN_W-1:0] rate_man;
    logic [EXP_W-1:0] rate_exp;
    logic [EXP_W-1:0] div_exp;
    logic [MAN_W-1:0] burst_man;
    logic [EXP_W-1:0] burst_exp;
  } bkt_cfg_t;

  typedef enum logic [1:0] {
    COL_GREEN  = 2'd0,
    COL_YELLOW = 2'd1,
    COL_RED    = 2'd2
  } colour_e;

  // refill per period in 1/256 token units
  function automatic logic [REF_W-1:0] refill_fx(input logic [MAN_W-1:0] m,
                                                 input logic [EXP_W-1:0] e);
    return REF_W'({1'b1, m}) << e;
  endfunction

  // burst cap, truncated to whole tokens, returned in 1/256 token units
  function automatic logic [CAP_W-1:0] burst_cap_fx(input logic [MAN_W-1:0] m,
                                                    input logic [EXP_W-1:0] e);
    logic [CAP_W-1:0] raw;
    raw = CAP_W'({1'b1, m}) << (5'(e) + 5'd1);
    return {raw[CAP_W-1:FRAC_W], {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [EXP_W-1:0] div_clamp(input logic [EXP_W-1:0] d);
    return (d > EXP_W'(DIV_MAX)) ? EXP_W'(DIV_MAX) : d;
  endfunction

endpackage

// File: rtl/shaper_cfg_regs.sv
module shaper_cfg_regs
  import shaper_pkg::*;
#(
  parameter int NB      = 2,
  parameter int RST_DIV = 12,
  localparam int SEL_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  bkt_cfg_t         wdata_i,
  output bkt_cfg_t         cfg_q_o   [NB],
  output bkt_cfg_t         cfg_nxt_o [NB]
);

  localparam bkt_cfg_t RST_CFG = '{
    en:        1'b1,
    rate_man:  '0,
    rate_exp:  '0,
    div_exp:   EXP_W'(RST_DIV),
    burst_man: '0,
    burst_exp: '0
  };

  for (genvar i = 0; i < NB; i++) begin : g_entry
    bkt_cfg_t held_q;
    logic     hit;

    assign hit          = we_i && (sel_i == SEL_W'(i));
    assign cfg_nxt_o[i] = hit ? wdata_i : held_q;
    assign cfg_q_o[i]   = held_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= RST_CFG;
      else        held_q <= cfg_nxt_o[i];
    end
  end

endmodule

// File: rtl/shaper_tick_gen.sv
module shaper_tick_gen
  import shaper_pkg::*;
#(
  parameter int TICKS = 240,
  parameter int CNT_W = $clog2(TICKS) + DIV_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [EXP_W-1:0] div_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = (CNT_W'(TICKS) << div_clamp(div_i)) - CNT_W'(1);
  assign tick_o = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R2

endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket
  import shaper_pkg::*;
#(
  parameter int TICKS   = 240,
  parameter int LEN_W   = 16,
  parameter int ACC_W   = 27,
  parameter logic [CAP_W-1:0] RST_CAP = '0,
  localparam int XW     = ACC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bkt_cfg_t         cfg_i,
  input  bkt_cfg_t         cfg_nxt_i,
  input  logic             load_i,
  input  logic             take_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             conform_o
);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [ACC_W-1:0] cap_acc;
  logic signed [ACC_W-1:0] len_acc;
  logic signed [ACC_W-1:0] load_acc;
  logic                    tick;
  logic                    deduct;

  shaper_tick_gen #(.TICKS(TICKS)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (load_i),
    .div_i   (cfg_i.div_exp),
    .tick_o  (tick)
  );

  assign cap_acc  = $signed(ACC_W'(burst_cap_fx(cfg_i.burst_man, cfg_i.burst_exp)));
  assign load_acc = $signed(ACC_W'(burst_cap_fx(cfg_nxt_i.burst_man, cfg_nxt_i.burst_exp)));
  assign len_acc  = $signed(ACC_W'({len_i, {FRAC_W{1'b0}}}));
  assign deduct   = take_i && cfg_i.en;

  always_comb begin
    logic signed [XW-1:0] sum;
    logic signed [XW-1:0] cap_x;
    logic signed [XW-1:0] floor_x;
    cap_x   = XW'(cap_acc);
    floor_x = $signed({3'b111, {(ACC_W-1){1'b0}}});
    sum     = XW'(acc_q);
    if (tick) begin
      sum = sum + $signed(XW'(refill_fx(cfg_i.rate_man, cfg_i.rate_exp)));
      if (sum > cap_x) sum = cap_x;
    end
    if (deduct) sum = sum - XW'(len_acc);
    if (sum < floor_x) sum = floor_x;
    if (load_i)         acc_d = load_acc;
    else if (!cfg_i.en) acc_d = cap_acc;
    else                acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= $signed(ACC_W'(RST_CAP));
    else        acc_q <= acc_d;
  end

  assign conform_o = !cfg_i.en || !acc_q[ACC_W-1];

  AST_CAP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load_i |=> acc_q <= $past(cap_acc)); // R3

  AST_EXACT_DEDUCT: assert property (@(posedge clk) disable iff (!rst_n)
    deduct && !tick && !load_i && !acc_q[ACC_W-1]
      |=> acc_q == $past(acc_q) - $past(len_acc)); // R4

  AST_RELOAD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> acc_q == cap_acc); // R7

  AST_OFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.en && !load_i |=> acc_q == $past(cap_acc)); // R8

endmodule

// File: rtl/dual_rate_shaper.sv
module dual_rate_shaper
  import shaper_pkg::*;
#(
  parameter int TICKS   = 240,
  parameter int LEN_W   = 16,
  parameter int RST_DIV = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic             cfg_en,
  input  logic [7:0]       cfg_rate_man,
  input  logic [3:0]       cfg_rate_exp,
  input  logic [3:0]       cfg_div_exp,
  input  logic [7:0]       cfg_burst_man,
  input  logic [3:0]       cfg_burst_exp,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             pkt_ready,
  output logic [1:0]       pkt_colour
);

  localparam int NB    = 2;
  localparam int PEAK  = 0;
  localparam int CMT   = 1;
  localparam int ACC_W = ((LEN_W + FRAC_W > CAP_W) ? LEN_W + FRAC_W : CAP_W) + 2;
  localparam logic [CAP_W-1:0] RST_CAP = burst_cap_fx('0, '0);

  bkt_cfg_t wdata;
  bkt_cfg_t cfg_q   [NB];
  bkt_cfg_t cfg_nxt [NB];
  logic     conform [NB];
  logic     take;
  logic     peak_ok;
  logic     cmt_ok;
  colour_e  colour;

  assign wdata = '{
    en:        cfg_en,
    rate_man:  cfg_rate_man,
    rate_exp:  cfg_rate_exp,
    div_exp:   cfg_div_exp,
    burst_man: cfg_burst_man,
    burst_exp: cfg_burst_exp
  };

  shaper_cfg_regs #(.NB(NB), .RST_DIV(RST_DIV)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we),
    .sel_i     (cfg_sel),
    .wdata_i   (wdata),
    .cfg_q_o   (cfg_q),
    .cfg_nxt_o (cfg_nxt)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bkt
    shaper_bucket #(
      .TICKS   (TICKS),
      .LEN_W   (LEN_W),
      .ACC_W   (ACC_W),
      .RST_CAP (RST_CAP)
    ) u_bkt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_i     (cfg_q[b]),
      .cfg_nxt_i (cfg_nxt[b]),
      .load_i    (cfg_we),
      .take_i    (take),
      .len_i     (pkt_len),
      .conform_o (conform[b])
    );
  end

  assign peak_ok   = conform[PEAK];
  assign cmt_ok    = conform[CMT];
  assign pkt_ready = peak_ok && !cfg_we;
  assign take      = pkt_valid && pkt_ready;

  always_comb begin
    if (!peak_ok)    colour = COL_RED;
    else if (cmt_ok) colour = COL_GREEN;
    else             colour = COL_YELLOW;
  end
  assign pkt_colour = colour;

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !pkt_ready); // R7

  AST_RED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_colour == COL_RED |-> !pkt_ready); // R5

  AST_COLOUR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_colour != 2'b11); // R5

endmodule

// File: tb/tb_dual_rate_shaper.sv
`timescale 1ns/1ps
module tb_dual_rate_shaper;

  localparam int TK = 4;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0, cfg_en = 1'b0;
  logic [7:0]  cfg_rate_man = '0, cfg_burst_man = '0;
  logic [3:0]  cfg_rate_exp = '0, cfg_div_exp = '0, cfg_burst_exp = '0;
  logic        pkt_valid = 1'b0;
  logic [15:0] pkt_len = '0;
  logic        pkt_ready;
  logic [1:0]  pkt_colour;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dual_rate_shaper #(.TICKS(TK), .LEN_W(16), .RST_DIV(12)) dut (.*);

  // rate_man, rate_exp, div_exp, burst_man, burst_exp, len, edges until eligible
  localparam int TV [NV][7] = '{
    '{  0,  0,  0,   0,  0,     3,     4},  // 1 token/period, owe 1
    '{128,  1,  1,   0,  0,     8,    16},  // 3 tokens, owe 6, period 8
    '{128,  0,  0,   0,  0,     5,     8},  // 1.5 tokens, owe 3
    '{  0,  0, 12,   0,  0,     3, 16384},  // slowest code
    '{  0,  0, 15,   0,  0,     3, 16384},  // divider clamps to 12
    '{255, 15,  0, 255, 14, 65535,     4},  // fastest code, large cap
    '{  0,  3,  2,   0,  0,    10,    16},  // 8 tokens, owe 8, period 16
    '{255,  0,  0,   0,  0,     4,     8}   // 1.996 tokens, owe 2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called and returns just after a falling edge
  task automatic wr(input bit sel, input bit en, input int rm, input int re,
                    input int de, input int bm, input int be);
    cfg_we = 1'b1; cfg_sel = sel; cfg_en = en;
    cfg_rate_man = 8'(rm); cfg_rate_exp = 4'(re); cfg_div_exp = 4'(de);
    cfg_burst_man = 8'(bm); cfg_burst_exp = 4'(be);
    #1 chk(pkt_ready == 1'b0, "R7 ready during write", int'(pkt_ready), 0);
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drain(input int len, input int lim, output int acc, output int grn,
                       output int yel);
    acc = 0; grn = 0; yel = 0;
    pkt_valid = 1'b1; pkt_len = 16'(len);
    for (int i = 0; i < lim; i++) begin
      #1;
      if (!pkt_ready) break;
      acc++;
      if (pkt_colour == 2'd0) grn++;
      else if (pkt_colour == 2'd1) yel++;
      @(negedge clk);
    end
    #1;
    if (acc < lim)
      chk(pkt_colour == 2'd2, "R5 red when held", int'(pkt_colour), 2);
    pkt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic burst_case(input int bm, input int be, input int len, input int exp_n);
    int a, g, y;
    wr(1, 0, 0, 0, 12, 0, 0);
    wr(0, 1, 0, 0, 12, bm, be);
    drain(len, 64, a, g, y);
    chk(a == exp_n, "R3 burst cap packet count", a, exp_n);
    chk(g == a, "R8 committed off gives green", g, a);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int a, g, y;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    #1 chk(pkt_ready == 1'b1, "R6 ready after reset", int'(pkt_ready), 1);
    chk(pkt_colour == 2'd0, "R6 green after reset", int'(pkt_colour), 0);
    @(negedge clk);
    drain(1, 64, a, g, y);
    chk(a == 3, "R6 reset cap accepts", a, 3);
    chk(g == 3, "R6 reset greens", g, 3);

    // R1 R2 R9 refill timing table
    for (int v = 0; v < NV; v++) begin
      wr(1, 0, 0, 0, 12, 0, 0);
      wr(0, 1, TV[v][0], TV[v][1], TV[v][2], TV[v][3], TV[v][4]);
      pkt_valid = 1'b1; pkt_len = 16'(TV[v][5]);
      @(posedge clk);
      @(negedge clk);
      pkt_valid = 1'b0;
      repeat (TV[v][6] - 2) @(posedge clk);
      @(negedge clk);
      #1 chk(pkt_ready == 1'b0, "R1/R2/R9 still held one edge early",
             int'(pkt_ready), 0);
      @(negedge clk);
      #1 chk(pkt_ready == 1'b1, "R1/R2/R9 eligible after refills",
             int'(pkt_ready), 1);
    end
    @(negedge clk);

    // R3 truncated burst caps
    burst_case(0,   0, 1, 3);
    burst_case(0,   0, 3, 1);
    burst_case(128, 3, 5, 5);
    burst_case(255, 0, 1, 4);
    burst_case(64,  2, 10, 2);
    burst_case(0,   4, 7, 5);

    // R3 saturation after a huge refill
    wr(1, 0, 0, 0, 12, 0, 0);
    wr(0, 1, 255, 15, 12, 0, 0);
    repeat (TK * 4096 + 8) @(negedge clk);
    drain(1, 64, a, g, y);
    chk(a == 3, "R3 saturated at cap", a, 3);

    // R4 R5 both buckets active: peak 24 tokens, committed 2 tokens
    wr(1, 1, 0, 0, 12, 0, 0);
    wr(0, 1, 0, 0, 12, 128, 3);
    drain(5, 64, a, g, y);
    chk(a == 5, "R4 peak-limited accepts", a, 5);
    chk(g == 1, "R5 green count", g, 1);
    chk(y == 4, "R5 yellow count", y, 4);

    // R7 write reloads the drained peak bucket
    #1 chk(pkt_ready == 1'b0, "R4 held when peak negative", int'(pkt_ready), 0);
    wr(1, 1, 0, 0, 12, 0, 0);
    #1 chk(pkt_ready == 1'b1, "R7 reload after write", int'(pkt_ready), 1);
    @(negedge clk);

    // R8 peak disabled: never held, committed still colours
    wr(0, 0, 0, 0, 12, 0, 0);
    drain(100, 10, a, g, y);
    chk(a == 10, "R8 peak off never holds", a, 10);
    chk(g == 1, "R8 committed green once", g, 1);
    chk(y == 9, "R8 rest yellow", y, 9);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule